// File: doc/BRIEF.md
# Triple Video Output Level Composer

This block is the clocked digital front end of a three-channel RGB video converter. Each beat carries three 8-bit pixel values and two shared controls. The first control, `video_en`, admits picture content. The second, `sync_on`, keeps a sync offset current running on the green channel. For each channel the block produces a 10-bit level code that stands for the total output current, counted in units of one data LSB. The analog current sources that turn these codes into voltages are not part of this block.

When `video_en` is high, a channel's level is its pixel value plus a black pedestal of 21 units. When `video_en` is low, both the pixel value and the pedestal are removed. The green channel also carries a 110-unit sync offset whenever `sync_on` is high. Driving `sync_on` low removes that offset, which forms the sync tip. The sync offset never overrides the blanking decision or the pixel data. It is simply added on top.

The block has one register stage. Beats enter on a valid/ready handshake and leave on a second valid/ready handshake. The block accepts a beat whenever its output slot is empty or is being drained in the same cycle: `in_ready = !out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, the output codes hold and no new beat is accepted. Reset is synchronous and active high.

Top module: `video_level_composer`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `out_valid` = 0 and all three level codes = 0.
- R2: A beat accepted at a rising edge (`in_valid` and `in_ready` both high) appears on the level codes with `out_valid` = 1 right after that same edge, which is one register stage of latency.
- R3: For an accepted beat with `video_en` = 1, the red and blue codes equal their pixel value plus 21.
- R4: For an accepted beat with `video_en` = 0, the red and blue codes are 0 whatever their pixel values.
- R5: The green code equals (`video_en` ? green pixel + 21 : 0) + (`sync_on` ? 110 : 0). In particular, green is 110 when `video_en` = 0 and `sync_on` = 1.
- R6: For an accepted beat with `video_en` = 0 and `sync_on` = 0, the green code is 0.
- R7: `sync_on` has no effect on the red and blue codes.
- R8: While `out_valid` = 1 and `out_ready` = 0, `in_ready` is 0, and the level codes and `out_valid` stay unchanged at the next edge.
- R9: `in_ready` equals `!out_valid || out_ready`. An edge where `in_ready` = 1 and `in_valid` = 0 leaves `out_valid` = 0.
- R10: The extreme codes are exact. White with sync gives green = 386 and red/blue = 276. Pixel 0 with `video_en` = 1 and `sync_on` = 1 gives green = 131.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all capture on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take a beat this cycle |
| pix_red | input | 8 | Red pixel value |
| pix_green | input | 8 | Green pixel value |
| pix_blue | input | 8 | Blue pixel value |
| video_en | input | 1 | High admits pixel data and pedestal; low blanks |
| sync_on | input | 1 | High keeps the green sync offset on; low gives the sync tip |
| out_valid | output | 1 | Level codes hold a beat |
| out_ready | input | 1 | Downstream takes the beat this cycle |
| lvl_red | output | 10 | Red level code |
| lvl_green | output | 10 | Green level code |
| lvl_blue | output | 10 | Blue level code |

## Verification
Since there is only one register stage, any wrong internal state shows at the ports one cycle after the beat that caused it. A blanking or sync term that is lost or misrouted gives a code that is off by exactly 21 or 110 on the next cycle. A pipeline register that fails to hold during a stall changes a level code while `out_ready` is low, which is visible at the following edge. A wrong occupancy flag shows up at once as a mismatch between `in_ready` and `out_valid`. The bench checks all of this every clock against a behavioural model that sees only the port values.

// File: rtl/vlc_pkg.sv
package vlc_pkg;
  localparam int PIX_W   = 8;
  localparam int LVL_W   = 10;
  localparam int NUM_CH  = 3;
  localparam int BLACK_PED   = 21;
  localparam int SYNC_LIFT   = 110;

  typedef enum int {CH_RED = 0, CH_GREEN = 1, CH_BLUE = 2} chan_e;

  typedef logic [PIX_W-1:0] pix_t;
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/vlc_channel.sv
module vlc_channel #(
  parameter int PIX_W     = 8,
  parameter int LVL_W     = 10,
  parameter int PEDESTAL  = 21,
  parameter int SYNC_OFS  = 110,
  parameter bit HAS_SYNC  = 1'b0
) (
  input  logic [PIX_W-1:0] pix,
  input  logic             video_en,
  input  logic             sync_on,
  output logic [LVL_W-1:0] level
);
  localparam logic [LVL_W-1:0] PED_C  = LVL_W'(PEDESTAL);
  localparam logic [LVL_W-1:0] SYNC_C = LVL_W'(SYNC_OFS);

  logic [LVL_W-1:0] data_term;
  logic [LVL_W-1:0] sync_term;

  always_comb begin
    data_term = video_en ? (LVL_W'(pix) + PED_C) : '0;
  end

  generate
    if (HAS_SYNC) begin : g_sync
      always_comb sync_term = sync_on ? SYNC_C : '0;
    end else begin : g_nosync
      logic unused_sync;
      always_comb begin
        unused_sync = sync_on;
        sync_term   = '0;
      end
    end
  endgenerate

  always_comb level = data_term + sync_term;
endmodule

// File: rtl/vlc_stage.sv
module vlc_stage #(
  parameter int WIDTH = 30
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data
);
  logic             occ_q;
  logic [WIDTH-1:0] data_q;

  assign in_ready  = !occ_q || out_ready;
  assign out_valid = occ_q;
  assign out_data  = data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      occ_q  <= 1'b0;
      data_q <= '0;
    end else if (in_ready) begin
      occ_q <= in_valid;
      if (in_valid) data_q <= in_data;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (!out_valid && out_data == '0));
  // R2
  accept_show_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (out_valid && out_data == $past(in_data)));
  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  // R9
  bubble_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && in_ready) |=> !out_valid);
endmodule

// File: rtl/video_level_composer.sv
module video_level_composer
  import vlc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       pix_red,
  input  logic [7:0]       pix_green,
  input  logic [7:0]       pix_blue,
  input  logic             video_en,
  input  logic             sync_on,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [9:0]       lvl_red,
  output logic [9:0]       lvl_green,
  output logic [9:0]       lvl_blue
);
  localparam int PAY_W = NUM_CH * LVL_W;

  pix_t pix_arr [NUM_CH];
  lvl_t lvl_arr [NUM_CH];
  logic [PAY_W-1:0] pay_in, pay_out;

  assign pix_arr[CH_RED]   = pix_red;
  assign pix_arr[CH_GREEN] = pix_green;
  assign pix_arr[CH_BLUE]  = pix_blue;

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      vlc_channel #(
        .PIX_W(PIX_W), .LVL_W(LVL_W), .PEDESTAL(BLACK_PED), .SYNC_OFS(SYNC_LIFT),
        .HAS_SYNC(c == int'(CH_GREEN))
      ) u_ch (
        .pix(pix_arr[c]), .video_en(video_en), .sync_on(sync_on), .level(lvl_arr[c])
      );
      assign pay_in[c*LVL_W +: LVL_W] = lvl_arr[c];
    end
  endgenerate

  vlc_stage #(.WIDTH(PAY_W)) u_stage (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(pay_in),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(pay_out)
  );

  assign lvl_red   = pay_out[int'(CH_RED)*LVL_W   +: LVL_W];
  assign lvl_green = pay_out[int'(CH_GREEN)*LVL_W +: LVL_W];
  assign lvl_blue  = pay_out[int'(CH_BLUE)*LVL_W  +: LVL_W];

  // R3
  lit_ped_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && video_en) |=>
      (lvl_red == 10'($past(pix_red)) + 10'(BLACK_PED) && lvl_blue >= 10'(BLACK_PED)));
  // R4
  blank_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !video_en) |=> (lvl_red == '0 && lvl_blue == '0));
  // R5
  blank_sync_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !video_en && sync_on) |=> (lvl_green == 10'(SYNC_LIFT)));
  // R6
  tip_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !video_en && !sync_on) |=> (lvl_green == '0));
endmodule

// File: tb/video_level_composer_tb.sv
module video_level_composer_tb_top;
  logic clk = 1'b0;
  logic rst;
  logic in_valid, in_ready, video_en, sync_on, out_valid, out_ready;
  logic [7:0] pix_red, pix_green, pix_blue;
  logic [9:0] lvl_red, lvl_green, lvl_blue;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural model state
  int  m_valid = 0;
  int  m_r = 0, m_g = 0, m_b = 0;
  string m_tag_rb = "R1";
  string m_tag_g  = "R1";

  always #10 clk = ~clk;

  video_level_composer dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .pix_red(pix_red), .pix_green(pix_green), .pix_blue(pix_blue),
    .video_en(video_en), .sync_on(sync_on), .out_valid(out_valid),
    .out_ready(out_ready), .lvl_red(lvl_red), .lvl_green(lvl_green), .lvl_blue(lvl_blue)
  );

  always @(posedge clk) begin
    if (rst) begin
      m_valid = 0; m_r = 0; m_g = 0; m_b = 0;
      m_tag_rb = "R1"; m_tag_g = "R1";
    end else if (m_valid == 0 || out_ready) begin
      m_valid = in_valid ? 1 : 0;
      if (in_valid) begin
        m_r = video_en ? int'(pix_red) + 21 : 0;
        m_b = video_en ? int'(pix_blue) + 21 : 0;
        m_g = (video_en ? int'(pix_green) + 21 : 0) + (sync_on ? 110 : 0);
        m_tag_rb = video_en ? "R3" : "R4";
        m_tag_g  = (!video_en && !sync_on) ? "R6" : "R5";
      end
    end else begin
      m_tag_rb = "R8"; m_tag_g = "R8";
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // sample at negedge, then drive new inputs, then check the combinational ready
  task automatic step(input bit v, input bit rdy, input bit en, input bit sy,
                      input int r, input int g, input int b);
    @(negedge clk);
    chk({"R2 valid ", m_tag_rb}, int'(out_valid), m_valid);
    chk({m_tag_rb, " red"},   int'(lvl_red),   m_r);
    chk({m_tag_g,  " green"}, int'(lvl_green), m_g);
    chk({m_tag_rb, " blue"},  int'(lvl_blue),  m_b);
    in_valid = v; out_ready = rdy; video_en = en; sync_on = sy;
    pix_red = 8'(r); pix_green = 8'(g); pix_blue = 8'(b);
    #1;
    chk("R9 ready", int'(in_ready), (m_valid == 0 || rdy) ? 1 : 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1; in_valid = 0; out_ready = 1; video_en = 0; sync_on = 0;
    pix_red = 0; pix_green = 0; pix_blue = 0;
    repeat (3) @(posedge clk);
    // R1: reset state observed through step's first sample
    step(0, 1, 0, 0, 0, 0, 0);
    rst = 0;
    // R10 white with sync, R3
    step(1, 1, 1, 1, 255, 255, 255);
    step(1, 1, 1, 1, 0, 0, 0);       // R10 green 131
    step(1, 1, 1, 0, 100, 7, 200);   // R3, R7 sync off
    step(1, 1, 1, 1, 100, 7, 200);   // R7 same rb with sync on
    step(1, 1, 0, 1, 255, 255, 255); // R4, R5 blank level 110
    step(1, 1, 0, 0, 255, 255, 255); // R6 sync tip 0
    step(0, 1, 1, 1, 9, 9, 9);       // R9 bubble
    step(1, 0, 1, 0, 50, 60, 70);    // load then stall
    step(1, 0, 0, 1, 1, 2, 3);       // R8 hold
    step(1, 0, 1, 1, 4, 5, 6);       // R8 hold
    step(1, 1, 1, 1, 4, 5, 6);       // drain
    step(0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 3000; i++)
      step(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 2) != 0),
           1'($urandom), 1'($urandom),
           $urandom_range(0, 255), $urandom_range(0, 255), $urandom_range(0, 255));
    // R1 reset in mid-stream
    rst = 1;
    step(1, 0, 1, 1, 255, 255, 255);
    rst = 0;
    step(0, 1, 0, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0, 0, 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule